// File: doc/BRIEF.md
# Protection Region Configuration Registers

This block holds the programmable definitions of three memory protection regions over a 16-bit address space. Each region has a range register (base and size) and a policy register (six permission bits). A downstream access filter reads the live region definitions from flat output vectors. The register file is written and read one register per cycle, and every write carries a privilege tag.

The block decides whether each write is accepted. Regions 0 and 1 belong to privileged software. Region 2 may be programmed by either privilege level. A range write is also refused when the new span would leave the address space, or when it would intersect the span of another non-empty region. Two regions can therefore never overlap, whatever order software writes them in. A refused write leaves every register unchanged and raises a one-cycle error pulse.

Top module: `prot_region_cfg`

## Requirements
- R1: After reset, all range and policy registers are zero, so every region is empty. `rd_data` is zero and `wr_err` is low.
- R2: Register index `{region[1:0], sel}` selects a register: sel 0 is the range register and sel 1 is the policy register. In the range register, bits [15:0] are the base and bits [31:16] are the size. An accepted range write appears on `rgn_base`/`rgn_size` (region n at bits [16n+15:16n]) in the cycle after the write.
- R3: Policy bits are bit0 read, bit1 write and bit2 execute for non-privileged software, and bit3 read, bit4 write and bit5 execute for privileged software. Bits [31:6] ignore writes and read as zero. Region n appears on `rgn_perm[6n+5:6n]`.
- R4: A write to region 0 or 1 with `wr_priv` low is refused.
- R5: Region 2 accepts writes with `wr_priv` either low or high.
- R6: A range write whose span [base, base+size-1] intersects the span of any other non-empty region is refused. A span that only touches another span end to end is accepted.
- R7: A range with size zero is empty, never overlaps anything, and is accepted at any base.
- R8: A range write with base+size greater than 0x10000 is refused. A span ending exactly at 0xFFFF is accepted.
- R9: A refused write changes no register and drives `wr_err` high for exactly the following cycle. `wr_err` stays low after an accepted write or when no write occurs.
- R10: Register indices 6 and 7 are unmapped: writes to them are refused, and reads of them return zero. `rd_data` is zero in any cycle that does not follow a read.
- R11: A read and a write to the same register in the same cycle return the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_priv | input | 1 | Privilege tag of the write: 1 = privileged |
| wr_idx | input | 3 | Register index of the write: {region, sel} |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 3 | Register index of the read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| rgn_base | output | 48 | Base addresses of all regions, region n at [16n+15:16n] |
| rgn_size | output | 48 | Sizes of all regions, region n at [16n+15:16n] |
| rgn_perm | output | 18 | Permission bits of all regions, region n at [6n+5:6n] |

## Verification
A read and a write can land in the same cycle, including on the same register, while the write is being accepted or refused. The bench drives both strobes together in its random phase and in directed cases. In those cases the write targets a register that is then read, and the write is refused in some cases and accepted in others. Each read result is compared with a bench model that captures the register value before applying the write. The model is updated only afterwards, so a design that forwards the new value, or that loses the read when the write is refused, shows a miscompare.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

    localparam int ADDR_W = 16;
    localparam int PERM_W = 6;
    localparam int REG_W  = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] size;
        logic [ADDR_W-1:0] base;
    } range_t;

    typedef logic [PERM_W-1:0] perm_t;

    // end of span, one past the last address, in ADDR_W+1 bits
    function automatic logic [ADDR_W:0] span_end(range_t r);
        return {1'b0, r.base} + {1'b0, r.size};
    endfunction

    function automatic logic span_fits(range_t r);
        return span_end(r) <= (ADDR_W+1)'(1 << ADDR_W);
    endfunction

    function automatic logic spans_collide(range_t a, range_t b);
        if (a.size == '0 || b.size == '0) begin
            return 1'b0;
        end
        return ({1'b0, a.base} < span_end(b)) && ({1'b0, b.base} < span_end(a));
    endfunction

endpackage

// File: rtl/prot_owner_check.sv
module prot_owner_check #(
    parameter int NUM_RGN    = 3,
    parameter int OPEN_FIRST = 2,
    parameter int RGN_W      = 2
) (
    input  logic [RGN_W-1:0] rgn,
    input  logic             priv,
    output logic             rgn_ok,
    output logic             allow
);
    localparam int SLOTS = 1 << RGN_W;

    logic [SLOTS-1:0] exists_mask;
    logic [SLOTS-1:0] open_mask;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_RGN) begin : g_real
            assign exists_mask[g] = 1'b1;
            assign open_mask[g]   = (g >= OPEN_FIRST);
        end else begin : g_none
            assign exists_mask[g] = 1'b0;
            assign open_mask[g]   = 1'b0;
        end
    end

    assign rgn_ok = exists_mask[rgn];
    assign allow  = rgn_ok && (priv || open_mask[rgn]);

endmodule

// File: rtl/prot_span_check.sv
module prot_span_check
    import prot_cfg_pkg::*;
#(
    parameter int NUM_RGN = 3,
    parameter int RGN_W   = 2
) (
    input  range_t [NUM_RGN-1:0] cur,
    input  logic [RGN_W-1:0]     tgt,
    input  range_t               cand,
    output logic                 fits,
    output logic                 clear
);
    logic [NUM_RGN-1:0] hit;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
        assign hit[g] = (tgt != RGN_W'(g)) && spans_collide(cand, cur[g]);
    end

    assign fits  = span_fits(cand);
    assign clear = ~|hit;

endmodule

// File: rtl/prot_region_cfg.sv
module prot_region_cfg
    import prot_cfg_pkg::*;
#(
    parameter int  NUM_RGN    = 3,
    parameter int  OPEN_FIRST = 2,
    localparam int IDX_W      = $clog2(2 * NUM_RGN),
    localparam int RGN_W      = IDX_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_priv,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      rd_en,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [REG_W-1:0]          rd_data,
    output logic                      wr_err,
    output logic [NUM_RGN*ADDR_W-1:0] rgn_base,
    output logic [NUM_RGN*ADDR_W-1:0] rgn_size,
    output logic [NUM_RGN*PERM_W-1:0] rgn_perm
);
    typedef struct packed {
        range_t [NUM_RGN-1:0] rng;
        perm_t  [NUM_RGN-1:0] perm;
        logic   [REG_W-1:0]   rdata;
        logic                 err;
    } state_t;

    state_t st_d, st_q;

    logic [RGN_W-1:0] wr_rgn, rd_rgn;
    logic             wr_is_pol, rd_is_pol;
    logic             wr_rgn_ok, wr_allow;
    logic             rd_rgn_ok, rd_allow_unused;
    logic             span_fits_w, span_clear_w;
    range_t           cand;

    assign wr_rgn    = wr_idx[IDX_W-1:1];
    assign wr_is_pol = wr_idx[0];
    assign rd_rgn    = rd_idx[IDX_W-1:1];
    assign rd_is_pol = rd_idx[0];
    assign cand      = range_t'(wr_data);

    prot_owner_check #(
        .NUM_RGN    (NUM_RGN),
        .OPEN_FIRST (OPEN_FIRST),
        .RGN_W      (RGN_W)
    ) u_wr_owner (
        .rgn    (wr_rgn),
        .priv   (wr_priv),
        .rgn_ok (wr_rgn_ok),
        .allow  (wr_allow)
    );

    // reads carry no privilege; only the region decode is used
    prot_owner_check #(
        .NUM_RGN    (NUM_RGN),
        .OPEN_FIRST (OPEN_FIRST),
        .RGN_W      (RGN_W)
    ) u_rd_decode (
        .rgn    (rd_rgn),
        .priv   (1'b1),
        .rgn_ok (rd_rgn_ok),
        .allow  (rd_allow_unused)
    );

    prot_span_check #(
        .NUM_RGN (NUM_RGN),
        .RGN_W   (RGN_W)
    ) u_span (
        .cur   (st_q.rng),
        .tgt   (wr_rgn),
        .cand  (cand),
        .fits  (span_fits_w),
        .clear (span_clear_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.err   = 1'b0;
        st_d.rdata = '0;

        // read sees the registers as they are before this cycle's write
        if (rd_en && rd_rgn_ok) begin
            if (rd_is_pol) begin
                st_d.rdata = REG_W'(st_q.perm[rd_rgn]);
            end else begin
                st_d.rdata = st_q.rng[rd_rgn];
            end
        end

        if (wr_en) begin
            if (!wr_allow) begin
                st_d.err = 1'b1;
            end else if (wr_is_pol) begin
                st_d.perm[wr_rgn] = wr_data[PERM_W-1:0];
            end else if (!span_fits_w || !span_clear_w) begin
                st_d.err = 1'b1;
            end else begin
                st_d.rng[wr_rgn] = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_flat
        assign rgn_base[g*ADDR_W +: ADDR_W] = st_q.rng[g].base;
        assign rgn_size[g*ADDR_W +: ADDR_W] = st_q.rng[g].size;
        assign rgn_perm[g*PERM_W +: PERM_W] = st_q.perm[g];
    end

    assign rd_data = st_q.rdata;
    assign wr_err  = st_q.err;

endmodule

// File: rtl/prot_region_cfg_chk.sv
module prot_region_cfg_chk
    import prot_cfg_pkg::*;
#(
    parameter int NUM_RGN    = 3,
    parameter int OPEN_FIRST = 2,
    parameter int IDX_W      = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      wr_priv,
    input logic [IDX_W-1:0]          wr_idx,
    input logic                      rd_en,
    input logic [IDX_W-1:0]          rd_idx,
    input logic [REG_W-1:0]          rd_data,
    input logic                      wr_err,
    input logic [NUM_RGN*ADDR_W-1:0] rgn_base,
    input logic [NUM_RGN*ADDR_W-1:0] rgn_size,
    input logic [NUM_RGN*PERM_W-1:0] rgn_perm
);
    logic any_overlap;
    logic any_overrun;

    always_comb begin
        any_overlap = 1'b0;
        any_overrun = 1'b0;
        for (int i = 0; i < NUM_RGN; i++) begin
            range_t ri;
            ri.base = rgn_base[i*ADDR_W +: ADDR_W];
            ri.size = rgn_size[i*ADDR_W +: ADDR_W];
            if (!span_fits(ri)) any_overrun = 1'b1;
            for (int j = i + 1; j < NUM_RGN; j++) begin
                range_t rj;
                rj.base = rgn_base[j*ADDR_W +: ADDR_W];
                rj.size = rgn_size[j*ADDR_W +: ADDR_W];
                if (spans_collide(ri, rj)) any_overlap = 1'b1;
            end
        end
    end

    p_locked_np_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv && (int'(wr_idx[IDX_W-1:1]) < OPEN_FIRST))
        |=> (wr_err && $stable(rgn_base) && $stable(rgn_size) && $stable(rgn_perm)));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_overlap);

    p_span_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_overrun);

    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rd_data == '0));

    p_perm_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(rd_idx[0])) |-> (rd_data[REG_W-1:PERM_W] == '0));

endmodule

bind prot_region_cfg prot_region_cfg_chk #(
    .NUM_RGN    (NUM_RGN),
    .OPEN_FIRST (OPEN_FIRST),
    .IDX_W      (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_priv  (wr_priv),
    .wr_idx   (wr_idx),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .wr_err   (wr_err),
    .rgn_base (rgn_base),
    .rgn_size (rgn_size),
    .rgn_perm (rgn_perm)
);

// File: tb/prot_region_cfg_bench.sv
module prot_region_cfg_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_priv = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_err;
    logic [47:0] rgn_base;
    logic [47:0] rgn_size;
    logic [17:0] rgn_perm;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_base [3];
    logic [15:0] m_size [3];
    logic [5:0]  m_perm [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_region_cfg u_prot_region_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .wr_err(wr_err), .rgn_base(rgn_base),
        .rgn_size(rgn_size), .rgn_perm(rgn_perm)
    );

    function automatic bit m_fits(logic [15:0] b, logic [15:0] s);
        return (32'(b) + 32'(s)) <= 32'h10000;
    endfunction

    function automatic bit m_hit(logic [15:0] b1, logic [15:0] s1,
                                 logic [15:0] b2, logic [15:0] s2);
        if (s1 == 0 || s2 == 0) return 1'b0;
        return (32'(b1) < 32'(b2) + 32'(s2)) && (32'(b2) < 32'(b1) + 32'(s1));
    endfunction

    task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_regions(string tag);
        logic [47:0] eb, es;
        logic [17:0] ep;
        for (int k = 0; k < 3; k++) begin
            eb[k*16 +: 16] = m_base[k];
            es[k*16 +: 16] = m_size[k];
            ep[k*6 +: 6]   = m_perm[k];
        end
        check({tag, " base"}, rgn_base, eb);
        check({tag, " size"}, rgn_size, es);
        check({tag, " perm"}, 48'(rgn_perm), 48'(ep));
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(logic we, logic pv, logic [2:0] wi, logic [31:0] wd,
                        logic re, logic [2:0] ri);
        logic [31:0] exp_rd;
        logic        exp_err;
        string       tw, tr;
        int          r;
        exp_rd = '0; exp_err = 1'b0; tw = "R2"; tr = "R10";
        if (re) begin
            if (ri >= 6) tr = "R10";
            else begin
                exp_rd = ri[0] ? {26'b0, m_perm[ri >> 1]} : {m_size[ri >> 1], m_base[ri >> 1]};
                tr = ri[0] ? "R3" : "R2";
                if (we && wi == ri) tr = "R11";
            end
        end
        if (we) begin
            r = int'(wi >> 1);
            if (wi >= 6) begin exp_err = 1'b1; tw = "R10"; end
            else if (r < 2 && !pv) begin exp_err = 1'b1; tw = "R4"; end
            else if (wi[0]) begin m_perm[r] = wd[5:0]; tw = (r == 2 && !pv) ? "R5" : "R3"; end
            else if (!m_fits(wd[15:0], wd[31:16])) begin exp_err = 1'b1; tw = "R8"; end
            else begin
                bit hit = 1'b0;
                for (int k = 0; k < 3; k++)
                    if (k != r && m_hit(wd[15:0], wd[31:16], m_base[k], m_size[k])) hit = 1'b1;
                if (hit) begin exp_err = 1'b1; tw = "R6"; end
                else begin
                    m_base[r] = wd[15:0]; m_size[r] = wd[31:16];
                    tw = (wd[31:16] == 0) ? "R7" : ((r == 2 && !pv) ? "R5" : "R2");
                end
            end
        end
        wr_en = we; wr_priv = pv; wr_idx = wi; wr_data = wd; rd_en = re; rd_idx = ri;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check({tr, " rd_data"}, 48'(rd_data), 48'(exp_rd));
        check({"R9 wr_err after ", tw}, 48'(wr_err), 48'(exp_err));
        check_regions(tw);
    endtask

    function automatic logic [31:0] rnd_range();
        logic [15:0] b, s;
        b = 16'($urandom);
        case ($urandom % 4)
            0: s = 16'h0;
            1: s = 16'($urandom % 64);
            2: s = 16'($urandom % 4096);
            default: s = 16'($urandom);
        endcase
        return {s, b};
    endfunction

    initial begin
        for (int k = 0; k < 3; k++) begin m_base[k] = '0; m_size[k] = '0; m_perm[k] = '0; end
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", 48'(rd_data), 48'h0);
        check("R1 wr_err", 48'(wr_err), 48'h0);
        check_regions("R1");

        step(1, 1, 3'd0, {16'h0100, 16'h1000}, 0, 0);  // R2 privileged range write
        step(0, 0, 0, 0, 1, 3'd0);                      // R2 read back
        step(1, 0, 3'd0, {16'h0010, 16'h5000}, 0, 0);  // R4 refused
        step(1, 0, 3'd3, 32'hFFFF_FFFF, 0, 0);          // R4 policy of region 1
        step(1, 0, 3'd5, 32'hFFFF_FFED, 0, 0);          // R5, R3 upper bits dropped
        step(0, 0, 0, 0, 1, 3'd5);                      // R3 read
        step(1, 0, 3'd4, {16'h0020, 16'h10F0}, 0, 0);  // R6 overlap tail
        step(1, 0, 3'd4, {16'h0020, 16'h0FF0}, 0, 0);  // R6 overlap head
        step(1, 0, 3'd4, {16'h0010, 16'h1100}, 0, 0);  // R6 touching, accepted
        step(1, 0, 3'd4, {16'h0010, 16'h0FF0}, 0, 0);  // R6 touching below, accepted
        step(1, 1, 3'd2, {16'h0000, 16'h1050}, 0, 0);  // R7 empty inside region 0
        step(1, 1, 3'd2, {16'h0100, 16'hFF00}, 0, 0);  // R8 ends at 0xFFFF
        step(1, 1, 3'd2, {16'h0100, 16'hFF01}, 0, 0);  // R8 runs past
        step(1, 1, 3'd6, 32'h1234_5678, 1, 3'd7);      // R10 unmapped
        step(1, 0, 3'd5, 32'h0000_0012, 1, 3'd5);      // R11 same register
        step(1, 0, 3'd0, {16'h0001, 16'h0000}, 1, 3'd0); // R11 with refused write
        step(0, 0, 0, 0, 0, 0);                        // R10 idle, R9 low

        for (int n = 0; n < 600; n++) begin
            logic [2:0] wi;
            logic [31:0] wd;
            wi = 3'($urandom % 8);
            wd = wi[0] ? $urandom : rnd_range();
            step(1'($urandom), 1'($urandom), wi, wd, 1'($urandom),
                 ($urandom % 3 == 0) ? wi : 3'($urandom % 8));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule